// File: doc/BRIEF.md
# Capture and Compare Event Timer

A single-channel counter timer driven from a small register port. A mode word picks the count source: stopped, every bus cycle, one bus cycle in sixteen, or falling edges on an external input pin. An 8-bit prescale field then divides the chosen source. The counter is compared against a reference value. Each time it reaches that value the timer either keeps counting or restarts from zero. The same match drives an output pin, either as a single low cycle or as a level that flips.

The input pin is brought into the clock domain and checked for edges. On the selected edge the current count is copied into a capture register. Both the capture and the reference events set sticky flags. Software clears a flag by writing 1 to its bit. A set flag raises either a DMA request or an interrupt, chosen by one select bit. The reference event reaches that output only when its own request enable is set.

A run bit in the mode word acts as a software reset. While it is 0 the counter and the prescaler are held at zero. Writing it from 1 to 0 returns every register to its reset value.

Top module: `dma_ref_timer`

## Requirements
- R1: The register map is: address 0 mode, 1 reference, 2 capture (read only), 3 count (read only), 4 events. Mode bits are: [0] run, [2:1] clock source, [3] restart, [4] reference request enable, [5] toggle output, [7:6] capture edge, [15:8] prescale, [16] DMA select. Event bits are [0] capture flag and [1] reference flag. After reset, mode, capture, count and events read 0, reference reads all ones, the output pin is high and both request outputs are low.
- R2: The counter advances once for every (prescale + 1) ticks of the selected source, so prescale 0 divides by 1 and 255 divides by 256.
- R3: The clock source encoding is: 00 stops the counter, 01 ticks every bus cycle, 10 ticks one bus cycle in sixteen from a free-running divider, and 11 ticks on each falling edge of the synchronized input pin.
- R4: A counter advance whose new value would equal the reference is a match. With restart 0 the counter takes that value and keeps incrementing. With restart 1 it loads zero instead, so the period is the reference value in counter advances.
- R5: The capture edge encoding is: 00 no capture, 01 rising only, 10 falling only, 11 either edge. A qualifying edge copies the current count into the capture register and sets the capture flag on the same clock edge.
- R6: With toggle 0, the output goes low for exactly the one cycle after each match. With toggle 1, the output inverts on each match.
- R7: An event sets its flag. Writing 1 to a flag bit at address 4 clears it, and writing 0 leaves it unchanged. If an event and a clear arrive in the same cycle, the event wins.
- R8: The request is the capture flag ORed with the reference flag gated by the reference request enable. It appears on dma_req when DMA select is 1 and on irq when it is 0. The reference request enable has no effect on capture requests.
- R9: While run is 0, the counter and prescaler stay at zero. A mode write that moves run from 1 to 0 restores all registers to their reset values.
- R10: A mode write made while run is already 1 stores the clock source as 00, whatever value is written.
- R11: The input pin passes through two flip-flops before edge detection, so a pin change made between edges k and k+1 is captured on edge k+3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |
| tin | input | 1 | External input pin |
| tout_n | output | 1 | Timer output pin, idle high |
| dma_req | output | 1 | DMA request level |
| irq | output | 1 | Interrupt request level |

## Verification
A table of counter runs pairs prescale values 0, 1, 2, 3 and 255 with free-running and restarting configurations. The final count shows whether the divider uses field+1 and whether the wrap happens at the reference value or one advance later. The reference flag in the same runs shows that a match is flagged when requests are disabled. Directed runs use the divide-by-16 source over a whole number of its periods and count pulses on the pin. Capture runs place a pin edge at a known cycle, so the captured value pins down the synchronizer latency and the edge qualification. Output runs sample the pin on the cycles around each match, which separates the single-cycle pulse from the toggle.

// File: rtl/dma_ref_timer.sv
module dma_ref_timer #(
  parameter int CW = 32,
  parameter int PW = 8,
  parameter int DIV = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  input  logic          tin,
  output logic          tout_n,
  output logic          dma_req,
  output logic          irq
);
  localparam int MW = 9 + PW;
  localparam int DVW = $clog2(DIV);

  logic [MW-1:0]  mode_q;
  logic [CW-1:0]  ref_q, cap_q, cnt_q;
  logic [PW-1:0]  pre_q;
  logic [DVW-1:0] div_q;
  logic [1:0]     ev_q;
  logic           s1_q, s2_q, sp_q, out_q;

  wire          run      = mode_q[0];
  wire [1:0]    clk_src  = mode_q[2:1];
  wire          restart  = mode_q[3];
  wire          ref_en   = mode_q[4];
  wire          toggle   = mode_q[5];
  wire [1:0]    cap_edge = mode_q[7:6];
  wire [PW-1:0] prescale = mode_q[8 +: PW];
  wire          dma_sel  = mode_q[8 + PW];

  wire mode_wr = wr_en && addr == 3'd0;
  wire ref_wr  = wr_en && addr == 3'd1;
  wire ev_wr   = wr_en && addr == 3'd4;
  wire sw_rst  = mode_wr && run && !wdata[0];

  wire rise = s2_q && !sp_q;
  wire fall = !s2_q && sp_q;

  logic src_tick;
  always_comb begin
    case (clk_src)
      2'b01:   src_tick = 1'b1;
      2'b10:   src_tick = div_q == DVW'(DIV - 1);
      2'b11:   src_tick = fall;
      default: src_tick = 1'b0;
    endcase
  end

  wire tick    = run && src_tick && pre_q == prescale;
  wire ref_hit = tick && (cnt_q + CW'(1)) == ref_q;

  logic cap_hit;
  always_comb begin
    case (cap_edge)
      2'b01:   cap_hit = rise;
      2'b10:   cap_hit = fall;
      2'b11:   cap_hit = rise || fall;
      default: cap_hit = 1'b0;
    endcase
    cap_hit = cap_hit && run;
  end

  wire [1:0] new_src = (run && wdata[2:1] != 2'b00) ? 2'b00 : wdata[2:1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       mode_q <= '0;
    else if (sw_rst)  mode_q <= '0;
    else if (mode_wr) mode_q <= {wdata[MW-1:3], new_src, wdata[0]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      ref_q <= '1;
    else if (sw_rst) ref_q <= '1;
    else if (ref_wr) ref_q <= wdata[CW-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       div_q <= '0;
    else              div_q <= div_q + DVW'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                 pre_q <= '0;
    else if (sw_rst || !run)    pre_q <= '0;
    else if (src_tick)          pre_q <= (pre_q == prescale) ? '0 : pre_q + PW'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                 cnt_q <= '0;
    else if (sw_rst || !run)    cnt_q <= '0;
    else if (tick)              cnt_q <= (ref_hit && restart) ? '0 : cnt_q + CW'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1_q <= 1'b0; s2_q <= 1'b0; sp_q <= 1'b0;
    end else begin
      s1_q <= tin; s2_q <= s1_q; sp_q <= s2_q;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       cap_q <= '0;
    else if (sw_rst)  cap_q <= '0;
    else if (cap_hit) cap_q <= cnt_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      ev_q <= '0;
    else if (sw_rst) ev_q <= '0;
    else begin
      ev_q[0] <= cap_hit || (ev_q[0] && !(ev_wr && wdata[0]));
      ev_q[1] <= ref_hit || (ev_q[1] && !(ev_wr && wdata[1]));
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      out_q <= 1'b1;
    else if (sw_rst) out_q <= 1'b1;
    else if (toggle) out_q <= out_q ^ ref_hit;
    else             out_q <= !ref_hit;

  wire req = ev_q[0] || (ev_q[1] && ref_en);
  assign dma_req = req && dma_sel;
  assign irq     = req && !dma_sel;
  assign tout_n  = out_q;

  always_comb begin
    rdata = '0;
    case (addr)
      3'd0: rdata[MW-1:0] = mode_q;
      3'd1: rdata[CW-1:0] = ref_q;
      3'd2: rdata[CW-1:0] = cap_q;
      3'd3: rdata[CW-1:0] = cnt_q;
      3'd4: rdata[1:0]    = ev_q;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/dma_ref_timer_chk.sv
module dma_ref_timer_chk #(parameter int CW = 32) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic [1:0]    clk_src,
  input logic          toggle,
  input logic          mode_wr,
  input logic          ref_hit,
  input logic          cap_hit,
  input logic [CW-1:0] cnt_q,
  input logic [CW-1:0] cap_q,
  input logic [1:0]    ev_q,
  input logic          tout_n,
  input logic          dma_req,
  input logic          irq
);
  // R8
  no_dual_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dma_req && irq));
  // R9
  held_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt_q == '0);
  // R3
  stopped_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && clk_src == 2'b00 && !mode_wr) |=> $stable(cnt_q));
  // R5
  capture_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_hit |=> cap_q == $past(cnt_q));
  // R7
  flag_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_hit || ref_hit) |=> (ev_q[0] || !$past(cap_hit)) && (ev_q[1] || !$past(ref_hit)));
  // R6
  pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tout_n && !toggle && !$past(toggle)) |-> $past(ref_hit));
endmodule

bind dma_ref_timer dma_ref_timer_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(mode_q[0]), .clk_src(mode_q[2:1]),
  .toggle(mode_q[5]), .mode_wr(mode_wr), .ref_hit(ref_hit), .cap_hit(cap_hit),
  .cnt_q(cnt_q), .cap_q(cap_q), .ev_q(ev_q), .tout_n(tout_n),
  .dma_req(dma_req), .irq(irq)
);

// File: tb/tb_dma_ref_timer.sv
module tb_dma_ref_timer;
  logic clk = 0, rst_n = 0, wr_en = 0, tin = 0;
  logic [2:0]  addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic tout_n, dma_req, irq;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  dma_ref_timer dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .tin(tin), .tout_n(tout_n),
    .dma_req(dma_req), .irq(irq));

  typedef struct packed {
    logic [7:0]  pre;
    logic        rs;
    logic [31:0] refv;
    logic [15:0] n;
    logic [31:0] cnt;
    logic        flag;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{8'd0,   1'b0, 32'hFFFF_FFFF, 16'd10,  32'd10, 1'b0},
    '{8'd3,   1'b0, 32'hFFFF_FFFF, 16'd20,  32'd5,  1'b0},
    '{8'd255, 1'b0, 32'hFFFF_FFFF, 16'd600, 32'd2,  1'b0},
    '{8'd0,   1'b1, 32'd7,         16'd20,  32'd6,  1'b1},
    '{8'd1,   1'b1, 32'd4,         16'd19,  32'd1,  1'b1},
    '{8'd2,   1'b0, 32'd5,         16'd30,  32'd10, 1'b1}
  };

  function automatic logic [31:0] mk(input logic run, input logic [1:0] src,
      input logic rs, input logic ren, input logic tg, input logic [1:0] ce,
      input logic [7:0] pre, input logic ds);
    return {15'd0, ds, pre, ce, tg, ren, rs, src, run};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v, c1;
    idle(3); rst_n = 1; idle(1);

    rd(0, v); chk("R1 mode reset", v, 0);
    rd(1, v); chk("R1 ref reset", v, 32'hFFFF_FFFF);
    rd(2, v); chk("R1 capture reset", v, 0);
    rd(3, v); chk("R1 count reset", v, 0);
    rd(4, v); chk("R1 events reset", v, 0);
    chk("R1 pins reset", {tout_n, dma_req, irq}, 3'b100);

    foreach (VEC[i]) begin
      wr(0, 0);
      wr(1, VEC[i].refv);
      wr(0, mk(0, 2'b01, VEC[i].rs, 0, 0, 2'b00, VEC[i].pre, 0));
      wr(0, mk(1, 2'b01, VEC[i].rs, 0, 0, 2'b00, VEC[i].pre, 0));
      idle(VEC[i].n);
      rd(3, v); chk("R2 R4 count", v, VEC[i].cnt);
      rd(4, v); chk("R7 ref flag", v, {30'd0, VEC[i].flag, 1'b0});
      chk("R8 ref request disabled", {dma_req, irq}, 2'b00);
    end

    // R9: 1->0 write restores registers
    wr(0, 0);
    rd(1, v); chk("R9 ref restored", v, 32'hFFFF_FFFF);
    rd(3, v); chk("R9 count cleared", v, 0);
    rd(4, v); chk("R9 events cleared", v, 0);
    wr(0, mk(0, 2'b01, 0, 0, 0, 2'b00, 8'd0, 0));
    idle(5);
    rd(3, v); chk("R9 held while not running", v, 0);

    // R3: divide by 16 over four full periods
    wr(0, mk(1, 2'b10, 0, 0, 0, 2'b00, 8'd0, 0));
    idle(64);
    rd(3, v); chk("R3 div16 count", v, 4);

    // R3 R11: external falling edges
    wr(0, 0);
    tin = 1; idle(4);
    wr(0, mk(0, 2'b11, 0, 0, 0, 2'b00, 8'd0, 0));
    wr(0, mk(1, 2'b11, 0, 0, 0, 2'b00, 8'd0, 0));
    for (int k = 0; k < 3; k++) begin
      tin = 0; idle(3); tin = 1; idle(3);
    end
    idle(4);
    rd(3, v); chk("R3 external edges", v, 3);

    // R5 R11: rising-edge capture
    wr(0, 0);
    tin = 0; idle(4);
    wr(0, mk(0, 2'b01, 0, 0, 0, 2'b01, 8'd0, 0));
    wr(0, mk(1, 2'b01, 0, 0, 0, 2'b01, 8'd0, 0));
    idle(5); tin = 1; idle(3);
    rd(2, v); chk("R5 R11 capture value", v, 7);
    rd(4, v); chk("R5 capture flag", v, 1);
    chk("R8 capture request ungated", {dma_req, irq}, 2'b01);
    tin = 0; idle(4);
    rd(2, v); chk("R5 falling edge ignored", v, 7);
    wr(4, 32'd1);
    rd(4, v); chk("R7 write-one clear", v, 0);
    chk("R7 request drops", irq, 0);

    // R10: write while running forces source to stop
    wr(0, mk(1, 2'b01, 0, 0, 0, 2'b11, 8'd0, 0));
    rd(0, v); chk("R10 source forced", {30'd0, v[2:1]}, 0);
    rd(3, c1); idle(3);
    rd(3, v); chk("R10 counter stopped", v, c1);
    tin = 1; idle(4);
    rd(2, v); chk("R5 any-edge capture", v, c1);

    // R6 pulse output with interrupt
    wr(0, 0);
    wr(1, 32'd3);
    wr(0, mk(0, 2'b01, 1, 1, 0, 2'b00, 8'd0, 0));
    wr(0, mk(1, 2'b01, 1, 1, 0, 2'b00, 8'd0, 0));
    idle(2); chk("R6 high before match", tout_n, 1);
    idle(1); chk("R6 pulse low", tout_n, 0);
    chk("R8 ref interrupt", {dma_req, irq}, 2'b01);
    idle(1); chk("R6 pulse one cycle", tout_n, 1);
    wr(0, mk(1, 2'b00, 1, 1, 0, 2'b00, 8'd0, 0));
    wr(4, 32'd2);
    rd(4, v); chk("R7 ref flag cleared", v, 0);

    // R6 toggle output with DMA
    wr(0, 0);
    wr(1, 32'd2);
    wr(0, mk(0, 2'b01, 1, 1, 1, 2'b00, 8'd0, 1));
    wr(0, mk(1, 2'b01, 1, 1, 1, 2'b00, 8'd0, 1));
    idle(2); chk("R6 toggle first", tout_n, 0);
    chk("R8 ref DMA", {dma_req, irq}, 2'b10);
    idle(1); chk("R6 toggle holds", tout_n, 0);
    idle(1); chk("R6 toggle second", tout_n, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule